// File: doc/BRIEF.md
# Burst Address Order Generator

This block produces the word-aligned address of every data phase in a bus burst. The initiator pulses a start strobe with its first byte address. The two low bits of that address are not part of the address. They select how the burst walks through memory: linear incrementing, a toggle order inside each cache line, or a wrap order inside each cache line. The fourth code is reserved. The cache line size, in 32-bit words, is sampled with the same strobe.

After start, the generator presents the current phase address and moves to the next one each time the data-transfer-accepted strobe is high. The toggle and wrap orders run through a whole line. They then move to the next line and begin again at the same word offset the burst started from. A reserved code, or a line size other than 4, 8 or 16 words, makes the burst single-word. In that case `last_phase` is raised for the first phase and the generator goes idle once that phase is accepted.

Top module: `burst_order_gen`

## Requirements
- R1: After reset, `active` is 0, `last_phase` is 0 and `addr` is 0.
- R2: A cycle with `start` high loads the generator, and restarts it if a burst is running. On the next cycle `active` is 1 and `addr` equals `start_addr` with bits [1:0] cleared; `addr[1:0]` is always 00.
- R3: While `active` is 1 and `xfer_ack` is 0, `addr` holds its value.
- R4: Code 00 (`start_addr[1:0]`) is linear: each accepted phase adds 4 to `addr`, with no line boundary.
- R5: Code 01 is toggle order. The word offset within the line is the start offset XOR the phase count within the line (16-byte line from 0x0C gives 0x0C, 0x08, 0x04, 0x00).
- R6: Code 10 is wrap order. The word offset is the start offset plus the phase count, modulo the line size (16-byte line from 0x0C gives 0x0C, 0x00, 0x04, 0x08).
- R7: In toggle and wrap order, once a full line has been accepted, the next address lies in the following line at the starting word offset (0x1C after the first line in R5 and R6), and the order then repeats.
- R8: Code 11 is reserved. `last_phase` is 1 during the first phase, and after that phase is accepted `active` returns to 0.
- R9: A `line_words` value other than 4, 8 or 16 (including 0) forces a single-word burst in every code: `last_phase` is 1 in the first phase and `active` falls after it is accepted.
- R10: Line sizes of 4, 8 and 16 words are all honoured, and the toggle and wrap spans follow the programmed size.
- R11: The code and the line size are captured only at start. Changes on `start_addr` and `line_words` during a burst do not affect the sequence.
- R12: In a burst that is not single-word, `last_phase` stays 0 in every phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle burst start strobe |
| start_addr | input | ADDR_W (32) | First byte address; bits [1:0] carry the ordering code |
| line_words | input | LSZ_W (8) | Cache line size in 32-bit words |
| xfer_ack | input | 1 | Current data phase accepted |
| addr | output | ADDR_W (32) | Byte address of the current data phase |
| active | output | 1 | A burst is in progress |
| last_phase | output | 1 | The burst ends after the current phase |

## Verification
The bench builds the block with its default parameters: a 32-bit address, an 8-bit line-size field and supported lines of 4 to 16 words. With these settings all three supported line sizes can be tested, and so can unsupported values just below and above that range, such as 2 and 32. The 16-word line lets bursts of 20 or more phases cross a line boundary at a start offset other than zero. The 4-word line shows the toggle and wrap orders repeating over several lines within a short run.

// File: rtl/burst_order_pkg.sv
package burst_order_pkg;

  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_TOGGLE = 2'b01,
    ORD_WRAP   = 2'b10,
    ORD_RSVD   = 2'b11
  } ord_e;

  // word offset inside a line for toggle order
  function automatic logic [15:0] toggle_off(input logic [15:0] soff,
                                             input logic [15:0] k,
                                             input logic [15:0] mask);
    return (soff ^ k) & mask;
  endfunction

  // word offset inside a line for wrap order
  function automatic logic [15:0] wrap_off(input logic [15:0] soff,
                                           input logic [15:0] k,
                                           input logic [15:0] mask);
    return (soff + k) & mask;
  endfunction

  // number of words in a line of 2**lg words
  function automatic logic [15:0] line_len(input logic [3:0] lg);
    return 16'd1 << lg;
  endfunction

endpackage

// File: rtl/burst_line_decode.sv
module burst_line_decode #(
  parameter int LSZ_W  = 8,
  parameter int MIN_LG = 2,
  parameter int MAX_LG = 4,
  parameter int LG_W   = 3,
  parameter int CNT_W  = 4
) (
  input  logic [LSZ_W-1:0] line_words,
  output logic             size_ok,
  output logic [LG_W-1:0]  size_lg,
  output logic [CNT_W-1:0] size_mask
);
  logic [MAX_LG:MIN_LG] hit;

  for (genvar g = MIN_LG; g <= MAX_LG; g++) begin : g_size
    assign hit[g] = (line_words == LSZ_W'(1 << g));
  end

  always_comb begin
    size_lg = LG_W'(MIN_LG);
    for (int g = MIN_LG; g <= MAX_LG; g++) begin
      if (hit[g]) size_lg = LG_W'(g);
    end
  end

  assign size_ok   = |hit;
  assign size_mask = CNT_W'((32'd1 << size_lg) - 32'd1);

endmodule

// File: rtl/burst_step.sv
module burst_step
  import burst_order_pkg::*;
#(
  parameter int WA_W  = 30,
  parameter int LG_W  = 3,
  parameter int CNT_W = 4
) (
  input  ord_e             mode,
  input  logic [LG_W-1:0]  lg,
  input  logic [WA_W-1:0]  wa,
  input  logic [CNT_W-1:0] soff,
  input  logic [CNT_W-1:0] cnt,
  output logic [WA_W-1:0]  wa_next,
  output logic [CNT_W-1:0] cnt_next,
  output logic             line_end
);
  logic [15:0]     len;
  logic [15:0]     mask16;
  logic [CNT_W:0]  cnt_inc;
  logic [WA_W-1:0] base;
  logic [WA_W-1:0] base_next;
  logic [15:0]     off_next;

  always_comb begin
    len       = line_len(4'(lg));
    mask16    = len - 16'd1;
    cnt_inc   = {1'b0, cnt} + 1'b1;
    line_end  = (16'(cnt_inc) == len);
    cnt_next  = line_end ? '0 : cnt_inc[CNT_W-1:0];
    base      = wa & ~WA_W'(mask16);
    base_next = line_end ? base + WA_W'(len) : base;
    if (mode == ORD_TOGGLE)
      off_next = toggle_off(16'(soff), 16'(cnt_next), mask16);
    else
      off_next = wrap_off(16'(soff), 16'(cnt_next), mask16);
    if (mode == ORD_LINEAR)
      wa_next = wa + 1'b1;
    else
      wa_next = base_next | WA_W'(off_next);
  end

endmodule

// File: rtl/burst_ctl.sv
module burst_ctl
  import burst_order_pkg::*;
#(
  parameter int WA_W  = 30,
  parameter int LG_W  = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [WA_W-1:0]  start_wa,
  input  ord_e             start_mode,
  input  logic             start_single,
  input  logic [LG_W-1:0]  start_lg,
  input  logic [CNT_W-1:0] start_mask,
  input  logic             xfer_ack,
  input  logic [WA_W-1:0]  wa_next,
  input  logic [CNT_W-1:0] cnt_next,
  input  logic             line_end,
  output logic             active_q,
  output ord_e             mode_q,
  output logic             single_q,
  output logic [LG_W-1:0]  lg_q,
  output logic [WA_W-1:0]  wa_q,
  output logic [CNT_W-1:0] soff_q,
  output logic [CNT_W-1:0] cnt_q
);
  logic accept;
  logic advance;
  logic finish;

  assign accept  = active_q && xfer_ack && !start;
  assign advance = accept && !single_q;
  assign finish  = accept && single_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mode_q   <= ORD_LINEAR;
      single_q <= 1'b0;
      lg_q     <= '0;
      wa_q     <= '0;
      soff_q   <= '0;
      cnt_q    <= '0;
    end else if (start) begin
      active_q <= 1'b1;
      mode_q   <= start_mode;
      single_q <= start_single;
      lg_q     <= start_lg;
      wa_q     <= start_wa;
      soff_q   <= start_wa[CNT_W-1:0] & start_mask;
      cnt_q    <= '0;
    end else if (finish) begin
      active_q <= 1'b0;
    end else if (advance) begin
      wa_q  <= wa_next;
      cnt_q <= cnt_next;
    end
  end

  logic [CNT_W-1:0] mask_q;
  assign mask_q = CNT_W'((32'd1 << lg_q) - 32'd1);

  p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> active_q && wa_q == $past(start_wa));

  p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    active_q && !xfer_ack && !start |=> $stable(wa_q));

  p_linear_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    advance && mode_q == ORD_LINEAR |=> wa_q == $past(wa_q) + 1'b1);

  p_line_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    advance && mode_q != ORD_LINEAR && line_end |=>
      (wa_q & WA_W'(mask_q)) == WA_W'(soff_q) && cnt_q == '0);

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> cnt_q <= mask_q);

  p_single_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    finish |=> !active_q);

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
  import burst_order_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LSZ_W  = 8,
  parameter int MIN_LG = 2,
  parameter int MAX_LG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LSZ_W-1:0]  line_words,
  input  logic              xfer_ack,
  output logic [ADDR_W-1:0] addr,
  output logic              active,
  output logic              last_phase
);
  localparam int WA_W  = ADDR_W - 2;
  localparam int CNT_W = MAX_LG;
  localparam int LG_W  = $clog2(MAX_LG + 1);

  logic             size_ok;
  logic [LG_W-1:0]  size_lg;
  logic [CNT_W-1:0] size_mask;
  ord_e             start_mode;
  logic             start_single;

  logic             active_q;
  ord_e             mode_q;
  logic             single_q;
  logic [LG_W-1:0]  lg_q;
  logic [WA_W-1:0]  wa_q;
  logic [CNT_W-1:0] soff_q;
  logic [CNT_W-1:0] cnt_q;
  logic [WA_W-1:0]  wa_next;
  logic [CNT_W-1:0] cnt_next;
  logic             line_end;

  burst_line_decode #(
    .LSZ_W(LSZ_W), .MIN_LG(MIN_LG), .MAX_LG(MAX_LG),
    .LG_W(LG_W), .CNT_W(CNT_W)
  ) u_decode (
    .line_words(line_words),
    .size_ok   (size_ok),
    .size_lg   (size_lg),
    .size_mask (size_mask)
  );

  assign start_mode   = ord_e'(start_addr[1:0]);
  assign start_single = (start_mode == ORD_RSVD) || !size_ok;

  burst_ctl #(.WA_W(WA_W), .LG_W(LG_W), .CNT_W(CNT_W)) u_ctl (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .start_wa    (start_addr[ADDR_W-1:2]),
    .start_mode  (start_mode),
    .start_single(start_single),
    .start_lg    (size_lg),
    .start_mask  (size_mask),
    .xfer_ack    (xfer_ack),
    .wa_next     (wa_next),
    .cnt_next    (cnt_next),
    .line_end    (line_end),
    .active_q    (active_q),
    .mode_q      (mode_q),
    .single_q    (single_q),
    .lg_q        (lg_q),
    .wa_q        (wa_q),
    .soff_q      (soff_q),
    .cnt_q       (cnt_q)
  );

  burst_step #(.WA_W(WA_W), .LG_W(LG_W), .CNT_W(CNT_W)) u_step (
    .mode    (mode_q),
    .lg      (lg_q),
    .wa      (wa_q),
    .soff    (soff_q),
    .cnt     (cnt_q),
    .wa_next (wa_next),
    .cnt_next(cnt_next),
    .line_end(line_end)
  );

  assign addr       = {wa_q, 2'b00};
  assign active     = active_q;
  assign last_phase = active_q && single_q;

  p_no_last_multi_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active) && !last_phase |=> !last_phase || $past(start));

  p_reserved_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
    start && start_addr[1:0] == 2'b11 |=> last_phase);

endmodule

// File: tb/burst_order_gen_tb.sv
`timescale 1ns/1ps
module burst_order_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] start_addr = '0;
  logic [7:0]  line_words = '0;
  logic        xfer_ack = 1'b0;
  logic [31:0] addr;
  logic        active;
  logic        last_phase;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  typedef struct { logic [31:0] a; logic last; string req; } exp_t;
  exp_t sb[$];

  always #2.5 clk = ~clk;

  burst_order_gen dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .line_words(line_words), .xfer_ack(xfer_ack), .addr(addr),
    .active(active), .last_phase(last_phase)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] model_addr(input logic [31:0] sa, input int lw, input int i);
    int unsigned w0, s, base0, ln, k, off;
    w0 = sa >> 2;
    if (sa[1:0] == 2'b00) return (w0 + i) << 2;
    s     = w0 % lw;
    base0 = w0 - s;
    ln    = i / lw;
    k     = i % lw;
    if (sa[1:0] == 2'b01) off = s ^ k;
    else                  off = (s + k) % lw;
    return (base0 + ln * lw + off) << 2;
  endfunction

  // monitor: every accepted phase is compared with the scoreboard
  always @(negedge clk) begin
    if (rst_n && active && xfer_ack && !start) begin
      if (sb.size() == 0) begin
        chk(1'b0, "scoreboard-empty", addr, 32'hx);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(addr == e.a, e.req, addr, e.a);
        chk(last_phase == e.last, {e.req, " last_phase (R12/R8/R9)"},
            32'(last_phase), 32'(e.last));
        chk(addr[1:0] == 2'b00, "R2 alignment", addr, addr & ~32'h3);
      end
    end
  end

  task automatic burst(input logic [31:0] sa, input int lw, input int n,
                       input int gap, input string req);
    bit single;
    int cnt;
    single = (sa[1:0] == 2'b11) || !(lw == 4 || lw == 8 || lw == 16);
    cnt = single ? 1 : n;
    sb.delete();
    for (int i = 0; i < cnt; i++) begin
      exp_t e;
      e.a = single ? (sa & ~32'h3) : model_addr(sa, lw, i);
      e.last = single;
      e.req = req;
      sb.push_back(e);
    end
    @(posedge clk); #1;
    start = 1'b1; start_addr = sa; line_words = 8'(lw); xfer_ack = 1'b0;
    @(posedge clk); #1;
    start = 1'b0;
    // R11: inputs change after capture and must not disturb the burst
    start_addr = 32'hFFFF_FFF3; line_words = 8'd5;
    chk(active == 1'b1, "R2 active after start", 32'(active), 32'd1);
    chk(addr == (sa & ~32'h3), "R2 start address", addr, sa & ~32'h3);
    for (int i = 0; i < cnt; i++) begin
      xfer_ack = 1'b1;
      @(posedge clk); #1;
      xfer_ack = 1'b0;
      if (gap > 0 && active) begin
        logic [31:0] held;
        held = addr;
        repeat (gap) @(posedge clk);
        #1;
        chk(addr == held, "R3 hold without ack", addr, held);
      end
    end
    @(negedge clk);
    chk(sb.size() == 0, {req, " R11 all phases seen"}, 32'(sb.size()), 32'd0);
    if (single)
      chk(active == 1'b0, {req, " idle after single phase"}, 32'(active), 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk(active == 1'b0, "R1 active reset", 32'(active), 32'd0);
    chk(last_phase == 1'b0, "R1 last_phase reset", 32'(last_phase), 32'd0);
    chk(addr == 32'd0, "R1 addr reset", addr, 32'd0);
    rst_n = 1'b1;

    burst(32'h0000_100C, 4, 9, 0, "R4 linear");
    burst(32'h0000_0FF0, 16, 6, 2, "R4 linear gaps");
    burst(32'h0000_000D, 4, 10, 0, "R5 R7 toggle 4w");
    burst(32'h0000_0215, 8, 18, 1, "R5 R10 toggle 8w");
    burst(32'h0000_000E, 4, 10, 0, "R6 R7 wrap 4w");
    burst(32'h0000_2016, 8, 17, 0, "R6 R10 wrap 8w");
    burst(32'h0000_3026, 16, 36, 0, "R6 R7 R10 wrap 16w");
    burst(32'h0000_3029, 16, 20, 3, "R5 R10 toggle 16w");
    burst(32'h0000_040F, 8, 4, 0, "R8 reserved code");
    burst(32'h0000_0500, 0, 4, 0, "R9 size 0 linear");
    burst(32'h0000_0505, 2, 4, 0, "R9 size 2 toggle");
    burst(32'h0000_050A, 32, 4, 0, "R9 size 32 wrap");
    burst(32'h0000_0511, 12, 4, 0, "R9 size 12 toggle");
    // R12 restart: a fresh start while a multi-phase burst is running
    burst(32'h0000_0601, 4, 3, 0, "R12 pre-restart");
    burst(32'h0000_0702, 4, 6, 0, "R2 R12 restart wrap");

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule